// File: doc/BRIEF.md
# Dithered PWM Compare/Capture Channel

This block is a single compare/capture channel of a timer. It holds two 24-bit registers: a buffer that software writes, and an active register that the rest of the channel uses. In compare mode the active register is split into an integer compare value and a dither count. The integer part is compared with an external free-running counter on every cycle to form a PWM waveform. The dither count decides how many frames in each group of 16, 32 or 64 PWM frames are stretched by one extra high cycle. This gives an average duty cycle finer than one counter tick. The channel can also raise a flag when the counter equals the compare value, so that the enclosing timer can use the channel as its period source.

In capture mode a capture strobe latches the counter value into the buffer. A small two-state machine then moves it into the active register one cycle later, so the register that software reads is the second level of a two-stage pipeline. The capture state machine has two states. `CH_IDLE` waits; a capture strobe in capture mode takes the transition *capture-accept* to `CH_PROMOTE`. `CH_PROMOTE` copies the buffer into the active register. From there it takes *promote-done* back to `CH_IDLE`, or *capture-again* stays in `CH_PROMOTE` when another capture strobe arrives.

The resolution mode code selects the split of the register:

| Code | Dither bits | Group length |
|------|-------------|--------------|
| 0 | none | no dithering |
| 1 | 4 | 16 frames |
| 2 | 5 | 32 frames |
| 3 | 6 | 64 frames |

Top module: `pwm_dither_channel`

## Requirements
- R1: After reset, the readback, the waveform output and the period-match flag are all zero, and the dither state is cleared.
- R2: A write with `wr_en_i` goes only to the buffer. The active register, which appears on `rd_data_o`, takes the buffer value at the clock edge where `update_i` is high in compare mode, and not before.
- R3: The resolution code (0 none, 1 four bits, 2 five bits, 3 six bits) sets a shift s of 0, 4, 5 or 6. The compare value is active register bits 23:s. The dither count is bits s-1:0.
- R4: In compare mode, `wave_o` in the cycle after a clock edge equals (counter < compare value + E), where E is the current frame's extension bit; the counter and E are taken before that edge.
- R5: Each `frame_i` pulse adds the dither count d to an accumulator of width s. A carry out of the accumulator sets E for the frame that starts at that edge, so that exactly d of every 2^s frames get one extra high cycle.
- R6: With resolution code 0, or with a dither count of zero, no frame is extended. In mode 0 the low bits count as part of the compare value.
- R7: In capture mode a `capture_i` pulse stores the counter value shifted left by s into the buffer at the first edge. The value reaches `rd_data_o` at the second edge.
- R8: In capture mode `update_i` has no effect on the active register, and `wave_o` stays low.
- R9: With `match_freq_i` high in compare mode, `period_match_o` is high in the cycle after an edge at which the counter equalled the compare value. With `match_freq_i` low it stays low.
- R10: With `wide_i` low (16-bit timer), register bits 23:(16+s) read back as zero and are excluded from the compare value.
- R11: The frame counter wraps after 2^s frames, and at that wrap the accumulator is cleared, so each group starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 24 | Timer counter value |
| frame_i | input | 1 | Start-of-PWM-frame strobe |
| update_i | input | 1 | Buffer-to-register update strobe |
| capture_i | input | 1 | Capture event strobe |
| cap_mode_i | input | 1 | 1 = capture mode, 0 = compare mode |
| match_freq_i | input | 1 | Enables the period-match flag |
| res_mode_i | input | 2 | Resolution code 0..3 |
| wide_i | input | 1 | 1 = 24-bit timer, 0 = 16-bit timer |
| wr_en_i | input | 1 | Buffer write enable |
| wr_data_i | input | 24 | Buffer write data |
| wave_o | output | 1 | PWM waveform |
| period_match_o | output | 1 | Counter equalled compare value |
| rd_data_o | output | 24 | Active register readback |

## Verification
The hardest condition to reach is one where the accumulator's carries are counted over a whole group that starts from a known state. A window that starts partway through a group gives a total that depends on where it started. The stimulus first runs one frame in mode 0, which clears the accumulator and the frame counter. It then loads the new value through the buffer and the update strobe, switches the resolution code, and tallies the high cycles over exactly 16, 32 or 64 frames. The tally is compared with frames × compare value + d. The two-stage capture path is observed at both edges to show that the readback changes only at the second edge.

// File: rtl/pwm_dith_pkg.sv
package pwm_dith_pkg;

    localparam int DITH_MAX = 6;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_D4   = 2'd1,
        RES_D5   = 2'd2,
        RES_D6   = 2'd3
    } res_mode_e;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_PROMOTE = 1'b1
    } cap_state_e;

    function automatic logic [2:0] dith_shift(res_mode_e m);
        logic [2:0] s;
        s = 3'd0;
        unique case (m)
            RES_NONE: s = 3'd0;
            RES_D4:   s = 3'd4;
            RES_D5:   s = 3'd5;
            RES_D6:   s = 3'd6;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
    import pwm_dith_pkg::*;
#(
    parameter int REG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_mode_i,
    input  logic             capture_i,
    input  logic             update_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [REG_W-1:0] cnt_i,
    input  logic [2:0]       shift_i,
    output logic [REG_W-1:0] reg_o
);

    cap_state_e       state_q, state_d;
    logic [REG_W-1:0] buf_q, reg_q;
    logic             cap_ev;

    assign cap_ev = cap_mode_i & capture_i;
    assign reg_o  = reg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: capture-accept, capture-again, promote-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:    if (cap_ev)  state_d = CH_PROMOTE;
            CH_PROMOTE: if (!cap_ev) state_d = CH_IDLE;
        endcase
    end

    // Outputs of the state machine: buffer and active register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            reg_q <= '0;
        end else begin
            if (cap_ev)       buf_q <= cnt_i << shift_i;
            else if (wr_en_i) buf_q <= wr_data_i;

            if (state_q == CH_PROMOTE)        reg_q <= buf_q;
            else if (update_i && !cap_mode_i) reg_q <= buf_q;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !(update_i && !cap_mode_i)) |=> $stable(reg_q));

    assert_promote_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PROMOTE) |=> (reg_q == $past(buf_q)));

    assert_cap_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (buf_q == $past(cnt_i << shift_i)));

    assert_cap_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_i && state_q == CH_IDLE) |=> $stable(reg_q));

endmodule

// File: rtl/pwm_ch_dither.sv
module pwm_ch_dither #(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic [2:0]    shift_i,
    input  logic [DW-1:0] dith_src_i,
    output logic          extra_o
);

    logic [DW:0]   grp;
    logic [DW-1:0] mask_n, dith_cnt, acc_q, frame_cnt_q;
    logic [DW:0]   sum;
    logic          carry, group_end, enabled, extra_q;

    assign grp       = (DW+1)'(1) << shift_i;
    assign mask_n    = DW'(grp - (DW+1)'(1));
    assign dith_cnt  = dith_src_i & mask_n;
    assign sum       = {1'b0, acc_q} + {1'b0, dith_cnt};
    assign carry     = sum > {1'b0, mask_n};
    assign group_end = frame_cnt_q >= mask_n;
    assign enabled   = shift_i != 3'd0;
    assign extra_o   = extra_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q       <= '0;
            frame_cnt_q <= '0;
            extra_q     <= 1'b0;
        end else if (frame_i) begin
            if (!enabled) begin
                acc_q       <= '0;
                frame_cnt_q <= '0;
                extra_q     <= 1'b0;
            end else begin
                extra_q <= carry;
                if (group_end) begin
                    acc_q       <= '0;
                    frame_cnt_q <= '0;
                end else begin
                    acc_q       <= sum[DW-1:0] & mask_n;
                    frame_cnt_q <= frame_cnt_q + 1'b1;
                end
            end
        end
    end

    assert_zero_dither_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && dith_cnt == '0) |=> !extra_q);

    assert_group_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && enabled && group_end) |=> (frame_cnt_q == '0 && acc_q == '0));

endmodule

// File: rtl/pwm_ch_wave.sv
module pwm_ch_wave #(
    parameter int REG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] cnt_i,
    input  logic [REG_W-1:0] cmp_i,
    input  logic             extra_i,
    input  logic             cap_mode_i,
    input  logic             match_freq_i,
    output logic             wave_o,
    output logic             period_match_o
);

    logic [REG_W:0] eff;
    logic           wave_d, pm_d;

    assign eff    = {1'b0, cmp_i} + (REG_W+1)'(extra_i);
    assign wave_d = !cap_mode_i && ({1'b0, cnt_i} < eff);
    assign pm_d   = match_freq_i && !cap_mode_i && (cnt_i == cmp_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_o         <= 1'b0;
            period_match_o <= 1'b0;
        end else begin
            wave_o         <= wave_d;
            period_match_o <= pm_d;
        end
    end

    assert_cap_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode_i |=> !wave_o);

    assert_pm_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !match_freq_i |=> !period_match_o);

    assert_wave_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode_i && cnt_i == '0 && cmp_i != '0) |=> wave_o);

endmodule

// File: rtl/pwm_dither_channel.sv
module pwm_dither_channel
    import pwm_dith_pkg::*;
#(
    parameter int REG_W    = 24,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] count_i,
    input  logic             frame_i,
    input  logic             update_i,
    input  logic             capture_i,
    input  logic             cap_mode_i,
    input  logic             match_freq_i,
    input  logic [1:0]       res_mode_i,
    input  logic             wide_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             wave_o,
    output logic             period_match_o,
    output logic [REG_W-1:0] rd_data_o
);

    localparam int LIM_W = REG_W + DITH_MAX + 1;

    res_mode_e        res;
    logic [2:0]       shift;
    logic [LIM_W-1:0] lim;
    logic [REG_W-1:0] narrow_mask, live_mask, reg_val, masked, cmp;
    logic             extra;

    assign res         = res_mode_e'(res_mode_i);
    assign shift       = dith_shift(res);
    assign lim         = LIM_W'(1) << (NARROW_W + int'(shift));
    assign narrow_mask = REG_W'(lim - LIM_W'(1));
    assign live_mask   = wide_i ? '1 : narrow_mask;
    assign masked      = reg_val & live_mask;
    assign cmp         = masked >> shift;
    assign rd_data_o   = masked;

    pwm_ch_regs #(.REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_mode_i (cap_mode_i),
        .capture_i  (capture_i),
        .update_i   (update_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .cnt_i      (count_i),
        .shift_i    (shift),
        .reg_o      (reg_val)
    );

    pwm_ch_dither #(.DW(DITH_MAX)) u_dither (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_i),
        .shift_i    (shift),
        .dith_src_i (masked[DITH_MAX-1:0]),
        .extra_o    (extra)
    );

    pwm_ch_wave #(.REG_W(REG_W)) u_wave (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt_i          (count_i),
        .cmp_i          (cmp),
        .extra_i        (extra),
        .cap_mode_i     (cap_mode_i),
        .match_freq_i   (match_freq_i),
        .wave_o         (wave_o),
        .period_match_o (period_match_o)
    );

    assert_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_i && res == RES_NONE) |-> (rd_data_o[REG_W-1:NARROW_W] == '0));

endmodule

// File: tb/tb_pwm_dither_channel.sv
module tb_pwm_dither_channel;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] cnt;
    logic        frame, upd, cap, capm, mf, wide, wr;
    logic [1:0]  res;
    logic [23:0] wdata;
    logic        wave, pm;
    logic [23:0] rd;

    int checks = 0;
    int fails = 0;
    int tally_en = 0;
    int wave_hi = 0;
    int pm_hi = 0;
    bit done = 0;

    // Behavioural reference model state
    longint m_reg, m_buf, m_acc, m_fc;
    bit     m_pend, m_extra, m_wave, m_pm;

    always #10 clk = ~clk;  // 50 MHz

    pwm_dither_channel dut (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .frame_i(frame),
        .update_i(upd), .capture_i(cap), .cap_mode_i(capm),
        .match_freq_i(mf), .res_mode_i(res), .wide_i(wide),
        .wr_en_i(wr), .wr_data_i(wdata), .wave_o(wave),
        .period_match_o(pm), .rd_data_o(rd)
    );

    function automatic int shift_of(logic [1:0] r);
        case (r)
            2'd1: return 4;
            2'd2: return 5;
            2'd3: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic longint model_rd();
        longint mk;
        mk = wide ? 64'hFF_FFFF : (((64'd1 << (16 + shift_of(res))) - 1) & 64'hFF_FFFF);
        return m_reg & mk;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 0; m_buf = 0; m_pend = 0; m_acc = 0; m_fc = 0;
            m_extra = 0; m_wave = 0; m_pm = 0;
        end else begin
            int s;
            longint n, cmpv, d, tot, nreg, nbuf;
            bit nw, np;
            s    = shift_of(res);
            n    = 64'd1 << s;
            cmpv = model_rd() >> s;
            nw   = !capm && (longint'(cnt) < cmpv + longint'(m_extra));
            np   = mf && !capm && (longint'(cnt) == cmpv);
            nreg = m_reg;
            if (m_pend) nreg = m_buf;
            else if (upd && !capm) nreg = m_buf;
            nbuf = m_buf;
            if (capm && cap) nbuf = (longint'(cnt) << s) & 64'hFF_FFFF;
            else if (wr) nbuf = longint'(wdata);
            if (frame) begin
                if (s == 0) begin
                    m_acc = 0; m_fc = 0; m_extra = 0;
                end else begin
                    d = m_reg % n;
                    tot = m_acc + d;
                    m_extra = (tot >= n);
                    if (m_fc >= n - 1) begin m_fc = 0; m_acc = 0; end
                    else begin m_fc = m_fc + 1; m_acc = tot % n; end
                end
            end
            m_reg = nreg; m_buf = nbuf; m_pend = capm && cap;
            m_wave = nw; m_pm = np;
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_model();
        chk(wave == m_wave, "R4 wave vs model", wave, m_wave);
        chk(pm == m_pm, "R9 match flag vs model", pm, m_pm);
        chk(longint'(rd) == model_rd(), "R2 readback vs model", rd, model_rd());
        if (tally_en != 0) begin
            if (wave) wave_hi++;
            if (pm) pm_hi++;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        upd = 0; cap = 0; wr = 0; frame = 0;
    endtask

    task automatic run_frames(int nf, int p);
        for (int f = 0; f < nf; f++) begin
            for (int c = 0; c < p; c++) begin
                cnt = 24'(c);
                frame = (c == 0);
                cyc();
            end
        end
    endtask

    task automatic load(logic [23:0] v);
        wr = 1; wdata = v; cyc();
        upd = 1; cyc();
    endtask

    task automatic tally(int nf, int p);
        wave_hi = 0; pm_hi = 0; tally_en = 1;
        run_frames(nf, p);
        tally_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cnt = 0; frame = 0; upd = 0; cap = 0; capm = 0; mf = 0;
        wide = 1; wr = 0; res = 0; wdata = 0;
        repeat (3) @(negedge clk);
        chk(rd == 0, "R1 readback after reset", rd, 0);
        chk(wave == 0, "R1 wave after reset", wave, 0);
        chk(pm == 0, "R1 match after reset", pm, 0);
        rst_n = 1;

        // R2: write reaches only the buffer until update
        cnt = 9;
        wr = 1; wdata = 24'h55; cyc();
        chk(rd == 0, "R2 register unchanged by write", rd, 0);
        upd = 1; cyc();
        chk(rd == 24'h55, "R2 register after update", rd, 24'h55);

        // R3/R6: mode 0, low bits are compare value, no extension
        load(24'h3);
        tally(4, 10);
        chk(wave_hi == 12, "R6 mode 0 high cycles", wave_hi, 12);

        // R5/R11: four dither bits, value 5, dither 3, two full groups
        res = 0; run_frames(1, 10);
        load(24'h53);
        res = 1;
        tally(16, 10);
        chk(wave_hi == 83, "R5 four-bit group high cycles", wave_hi, 83);
        tally(16, 10);
        chk(wave_hi == 83, "R11 second group after wrap", wave_hi, 83);

        // R5: six dither bits, value 2, dither 63
        res = 0; run_frames(1, 8);
        load(24'hBF);
        res = 3;
        tally(64, 8);
        chk(wave_hi == 191, "R5 six-bit group high cycles", wave_hi, 191);

        // R3/R6: five dither bits, value 7, dither 0
        res = 0; run_frames(1, 12);
        load(24'hE0);
        res = 2;
        tally(32, 12);
        chk(wave_hi == 224, "R6 zero dither high cycles", wave_hi, 224);
        chk(rd == 24'hE0, "R3 readback keeps both fields", rd, 24'hE0);

        // R9: period match
        res = 0; load(24'h7);
        mf = 1;
        tally(3, 10);
        chk(pm_hi == 3, "R9 match pulses", pm_hi, 3);
        mf = 0;
        tally(2, 10);
        chk(pm_hi == 0, "R9 no match when disabled", pm_hi, 0);

        // R10: narrow timer readback
        load(24'hFF_FFFF);
        wide = 0; res = 0; cyc();
        chk(rd == 24'h00_FFFF, "R10 narrow mode 0", rd, 24'h00_FFFF);
        res = 3; cyc();
        chk(rd == 24'h3F_FFFF, "R10 narrow six-bit", rd, 24'h3F_FFFF);
        wide = 1; cyc();
        chk(rd == 24'hFF_FFFF, "R10 wide readback", rd, 24'hFF_FFFF);

        // R7: capture through two stages
        capm = 1; res = 2; cnt = 13; cap = 1; cyc();
        chk(rd == 24'hFF_FFFF, "R7 not promoted after first edge", rd, 24'hFF_FFFF);
        cyc();
        chk(rd == 24'h1A0, "R7 promoted after second edge", rd, 24'h1A0);
        chk(wave == 0, "R8 wave low in capture", wave, 0);

        // R8: update ignored in capture mode
        wr = 1; wdata = 24'h123; cyc();
        upd = 1; cyc();
        cyc();
        chk(rd == 24'h1A0, "R8 update ignored in capture", rd, 24'h1A0);
        run_frames(1, 10);
        chk(wave == 0, "R8 wave still low", wave, 0);

        // R2: back in compare mode, update loads the buffer
        capm = 0; upd = 1; cyc();
        chk(rd == 24'h123, "R2 update after capture mode", rd, 24'h123);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule